// File: doc/BRIEF.md
# Five-Port Mode-Selectable Request Arbiter

This block shares a single lookup engine among five requesters. Requester slots 0 to 3 are the four lookup clients. Slot 4 is the packet-processor client. Each cycle the block looks at a request vector and a 2-bit policy input. When the engine is free, it issues a registered one-hot grant together with a grant-valid flag.

A grant stays with its owner until that owner pulses a done input. In the cycle the done pulse arrives, the arbiter already chooses the next owner, so the engine never sits idle between back-to-back users.

The policy can be changed at run time:
- Round-robin among all five slots.
- Strict priority with the lowest slot first.
- Strict priority with the highest slot first, which is the exact mirror of the previous order.

A new policy value applies only to grants issued after it changes. A grant already held is not affected.

Top module: `lookup_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grantVec` is all zero and `grantValid` is low.
- R2: `grantVec` has at most one bit set, and `grantValid` is high exactly when one bit is set.
- R3: A grant is issued on a clock edge to a slot whose request bit was high at that edge. It is visible at the outputs from that edge onward. Bit i of `reqVec` and `grantVec` is slot i: bits 0..3 are lookup clients 0..3, and bit 4 is the packet-processor client.
- R4: While a grant is held and `doneIn` is low, `grantVec` does not change, whatever `reqVec` or `mode` do.
- R5: A `doneIn` pulse while no grant is held has no effect: the outputs stay idle, and a later request is granted as usual.
- R6: On the edge where `doneIn` is high during a held grant, a new grant is chosen from the requests present at that edge, with no idle cycle in between.
- R7: With `mode` = 0 (round-robin), the search starts at the slot after the last granted slot and wraps from 4 to 0. The last granted slot is recorded for every grant in any mode. After reset the search starts at slot 0.
- R8: With `mode` = 1 (forward strict), the lowest-numbered requesting slot wins: client 0 first, the processor client last.
- R9: With `mode` = 2 (reverse strict), the highest-numbered requesting slot wins: the processor client first, client 0 last.
- R10: `mode` = 3 behaves exactly as round-robin.
- R11: When the engine is free, or being released by `doneIn`, and no request is present, no grant is asserted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | 5 | Request bits, one per slot (4 = processor client) |
| mode | input | 2 | Policy: 0 round-robin, 1 forward strict, 2 reverse strict, 3 round-robin |
| doneIn | input | 1 | Pulse from the current owner releasing the engine |
| grantVec | output | 5 | One-hot grant, registered |
| grantValid | output | 1 | High while a grant is held |

## Verification
The hardest situation to reach is a round-robin decision that depends on a history of grants made under other policies. The pointer carries over from the strict-priority phases, so the bench runs the strict-priority scenarios first and records which slot each one granted last. It then enters round-robin with all five requests high and checks that the rotation starts just past that recorded slot.

Back-to-back handovers are reached by raising `doneIn` in the same cycle as a changed request vector.

// File: rtl/lkarb_pkg.sv
package lkarb_pkg;
  typedef struct packed {
    logic load;   // capture the new pick into the grant register
    logic clear;  // drop the grant
  } arbStrobe_t;

  typedef enum logic [1:0] {
    MODE_RR     = 2'd0,
    MODE_FWD    = 2'd1,
    MODE_REV    = 2'd2,
    MODE_RR_ALT = 2'd3
  } arbMode_t;
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import lkarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       doneIn,
  output arbStrobe_t strb
);
  typedef enum logic {ST_FREE, ST_HELD} ctrlState_t;
  ctrlState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb = '0;
    if (stateQ == ST_FREE || doneIn) begin
      if (anyReq) begin
        strb.load = 1'b1;
        stateD = ST_HELD;
      end else begin
        strb.clear = 1'b1;
        stateD = ST_FREE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_FREE;
    else       stateQ <= stateD;
  end

  AST_FREE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FREE && !anyReq) |=> (stateQ == ST_FREE)); // R5
  AST_HELD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HELD && !doneIn) |=> ($past(strb) == '0)); // R4
endmodule

// File: rtl/arbPath.sv
module arbPath
  import lkarb_pkg::*;
#(
  parameter int NUM_REQ = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic [1:0]         mode,
  input  arbStrobe_t         strb,
  output logic               anyReq,
  output logic [NUM_REQ-1:0] grantVec
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] fwdOh, revOh, rrOh, pickOh, grantQ;
  logic [IDX_W-1:0]   lastIdx, pickIdx;
  logic               fwdFound, revFound, rrFound;

  assign anyReq = |reqVec;

  always_comb begin
    fwdOh = '0;
    fwdFound = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (!fwdFound && reqVec[i]) begin
        fwdOh[i] = 1'b1;
        fwdFound = 1'b1;
      end
    end
  end

  always_comb begin
    revOh = '0;
    revFound = 1'b0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (!revFound && reqVec[i]) begin
        revOh[i] = 1'b1;
        revFound = 1'b1;
      end
    end
  end

  always_comb begin
    rrOh = '0;
    rrFound = 1'b0;
    for (int off = 0; off < NUM_REQ; off++) begin
      int cand;
      cand = (int'(lastIdx) + 1 + off) % NUM_REQ;
      if (!rrFound && reqVec[IDX_W'(cand)]) begin
        rrOh[IDX_W'(cand)] = 1'b1;
        rrFound = 1'b1;
      end
    end
  end

  always_comb begin
    case (arbMode_t'(mode))
      MODE_FWD: pickOh = fwdOh;
      MODE_REV: pickOh = revOh;
      default:  pickOh = rrOh;
    endcase
    pickIdx = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (pickOh[i]) pickIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ  <= '0;
      lastIdx <= IDX_W'(NUM_REQ - 1);
    end else if (strb.clear) begin
      grantQ <= '0;
    end else if (strb.load) begin
      grantQ  <= pickOh;
      lastIdx <= pickIdx;
    end
  end

  assign grantVec = grantQ;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R2
  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (grantVec != '0) && ((grantVec & ~$past(reqVec)) == '0)); // R3
  AST_FWD_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && mode == MODE_FWD) |=>
      (($past(reqVec) & (grantVec - NUM_REQ'(1))) == '0)); // R8
  AST_REV_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && mode == MODE_REV) |=>
      (($past(reqVec) & ~(grantVec | (grantVec - NUM_REQ'(1)))) == '0)); // R9
endmodule

// File: rtl/lookup_arbiter.sv
module lookup_arbiter
  import lkarb_pkg::*;
#(
  parameter int NUM_REQ = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic [1:0]         mode,
  input  logic               doneIn,
  output logic [NUM_REQ-1:0] grantVec,
  output logic               grantValid
);
  arbStrobe_t strb;
  logic       anyReq;

  arbCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .anyReq (anyReq),
    .doneIn (doneIn),
    .strb   (strb)
  );

  arbPath #(.NUM_REQ(NUM_REQ)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .mode     (mode),
    .strb     (strb),
    .anyReq   (anyReq),
    .grantVec (grantVec)
  );

  assign grantValid = |grantVec;

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !doneIn) |=> $stable(grantVec)); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((!grantValid || doneIn) && reqVec == '0) |=> !grantValid); // R11
  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && doneIn && reqVec != '0) |=> grantValid); // R6
endmodule

// File: tb/tb_lookup_arbiter.sv
module tb_lookup_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] reqVec = '0;
  logic [1:0] mode = '0;
  logic       doneIn = 1'b0;
  logic [4:0] grantVec;
  logic       grantValid;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 0;

  lookup_arbiter dut (
    .clk        (clk),
    .rstN       (rstN),
    .reqVec     (reqVec),
    .mode       (mode),
    .doneIn     (doneIn),
    .grantVec   (grantVec),
    .grantValid (grantValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [4:0] expG);
    nChecks++;
    if (grantVec !== expG || grantValid !== (expG != '0)) begin
      nFails++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               tag, grantVec, grantValid, expG, (expG != '0));
    end
  endtask

  // drive at negedge, sample 1 time unit after the following posedge
  task automatic step(input logic [4:0] r, input logic [1:0] m, input logic d,
                      input logic [4:0] expG, input string tag);
    @(negedge clk);
    reqVec = r; mode = m; doneIn = d;
    @(posedge clk); #1;
    check(tag, expG);
    @(negedge clk);
    doneIn = 1'b0;
  endtask

  task automatic testReset;
    check("R1 in reset", 5'b00000);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 5'b00000);
  endtask

  task automatic testIdleDone;
    step(5'b00000, 2'd1, 1'b1, 5'b00000, "R5 done while idle");
    step(5'b00000, 2'd1, 1'b0, 5'b00000, "R5 still idle");
  endtask

  task automatic testForward;
    step(5'b11110, 2'd1, 1'b0, 5'b00010, "R8 lowest wins");
    step(5'b10100, 2'd1, 1'b1, 5'b00100, "R6 R8 handover");
    step(5'b10000, 2'd1, 1'b1, 5'b10000, "R8 processor alone");
    step(5'b00000, 2'd1, 1'b1, 5'b00000, "R11 release no req");
  endtask

  task automatic testReverse;
    step(5'b01111, 2'd2, 1'b0, 5'b01000, "R9 highest wins");
    step(5'b11111, 2'd2, 1'b1, 5'b10000, "R9 processor first");
    step(5'b00000, 2'd2, 1'b1, 5'b00000, "R11 release");
  endtask

  task automatic testHold;
    step(5'b00100, 2'd1, 1'b0, 5'b00100, "R3 grant to requester");
    step(5'b00001, 2'd2, 1'b0, 5'b00100, "R4 hold 1");
    step(5'b11011, 2'd0, 1'b0, 5'b00100, "R4 hold 2");
    step(5'b00000, 2'd2, 1'b0, 5'b00100, "R4 hold 3");
    step(5'b00000, 2'd0, 1'b1, 5'b00000, "R11 release after hold");
  endtask

  task automatic testRoundRobin;
    // last granted slot is 2 from the hold scenario
    step(5'b11111, 2'd0, 1'b0, 5'b01000, "R7 rr after 2");
    step(5'b11111, 2'd0, 1'b1, 5'b10000, "R7 rr to 4");
    step(5'b11111, 2'd0, 1'b1, 5'b00001, "R7 rr wrap to 0");
    step(5'b11111, 2'd0, 1'b1, 5'b00010, "R7 rr to 1");
    step(5'b00001, 2'd0, 1'b1, 5'b00001, "R7 rr single wrap");
    step(5'b11111, 2'd3, 1'b1, 5'b00010, "R10 mode3 after 0");
    step(5'b10001, 2'd3, 1'b1, 5'b10000, "R10 mode3 skip to 4");
    step(5'b00000, 2'd3, 1'b1, 5'b00000, "R11 final release");
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    testReset;
    testIdleDone;
    testForward;
    testReverse;
    testHold;
    testRoundRobin;
    finished = 1;
    report;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      report;
    end
  end
endmodule